// File: doc/BRIEF.md
# Iterative Radix-2 Integer Divider

This unit divides one 32-bit operand by another over many clock cycles for the execute stage of a five-stage integer pipeline. It accepts signed or unsigned operands. The 64-bit result goes to the pair of special multiply/divide result registers. The high half holds the remainder and the low half holds the quotient. Those registers and the instruction decode sit outside this block.

The execute stage holds `start_i` high together with the operands and a signedness flag. A controller then works through one restoring trial-subtraction step per clock. In each step the divisor magnitude is subtracted from the shifted partial remainder, and the quotient bit is set only when the difference is non-negative. Signed operands are reduced to magnitudes when they are loaded. The signs are restored at the end. A zero divisor skips the iteration and yields an all-zero result. While the unit is working it holds a stall request so that later instructions do not advance. A flush can abandon an operation that is in flight through `annul_i`.

The latency of a nonzero divide is fixed, whatever the operand values. `ready_o` stays asserted for as long as `start_i` is held, so the pipeline can collect the result at its own pace.

Top module: `idiv_core`

## Requirements
- R1: After reset, and while `start_i` is low, `ready_o` and `stall_o` are 0 and `result_o` is zero.
- R2: Unsigned divide (`signed_i`=0): `result_o[31:0]` is the quotient and `result_o[63:32]` is the remainder of `dividend_i / divisor_i`.
- R3: Signed divide (`signed_i`=1), two's-complement operands: the quotient is rounded toward zero and negated when the operand signs differ. The remainder carries the sign of the dividend. The most negative value divided by -1 gives quotient 0x80000000 and remainder 0.
- R4: For a nonzero divisor, `ready_o` first goes high after exactly 36 rising edges. The count includes the edge that accepts `start_i`.
- R5: `stall_o` is high from the cycle in which `start_i` is presented in the idle state until the cycle before `ready_o` rises. It is low whenever `ready_o` is high.
- R6: A zero divisor gives an all-zero 64-bit result. `ready_o` is high after 2 rising edges, counting the accepting edge.
- R7: With `start_i` held high, `ready_o` and `result_o` stay unchanged. One edge after `start_i` falls, `ready_o` is low. `result_o` is zero whenever `ready_o` is low.
- R8: If `annul_i` is high during iteration, the next edge returns the unit to idle. `ready_o` is never raised for that operation, `stall_o` drops, and a later operation completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request a divide; held until the result is taken |
| signed_i | input | 1 | 1 selects a two's-complement divide |
| annul_i | input | 1 | Abandons an operation that is iterating |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| result_o | output | 64 | {remainder, quotient}; zero unless ready |
| ready_o | output | 1 | Result valid |
| stall_o | output | 1 | Pipeline hold request |

## Verification
The bound checker watches on every cycle that a nonzero divide reaches ready exactly 36 edges after issue, that a zero divisor yields ready with an all-zero result one edge after its detection state, and that ready and stall are never high together. It also checks on every cycle that the result reads zero outside ready, that ready persists while start is held, and that an annul during iteration never produces ready on the next edge. The arithmetic itself shows up only in the bench's scenarios. These cover the quotient and remainder values for the four sign combinations, the most-negative-by-minus-one case, a divisor larger than the dividend, and full-scale unsigned operands, plus a later divide that completes cleanly after an aborted one.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ZERO = 2'd1,
    ST_ITER = 2'd2,
    ST_DONE = 2'd3
  } idiv_state_e;

endpackage

// File: rtl/idiv_rst_sync.sv
module idiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/idiv_negate.sv
// Conditional two's-complement negation, used for operand magnitudes
// on load and for the sign restore of quotient and remainder.
module idiv_negate #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         neg_i,
  output logic [W-1:0] val_o
);

  always_comb begin
    if (neg_i) begin
      val_o = ~val_i + {{(W-1){1'b0}}, 1'b1};
    end else begin
      val_o = val_i;
    end
  end

endmodule

// File: rtl/idiv_step.sv
// One restoring step: shift the next dividend bit into the partial
// remainder, subtract the divisor on trial, keep the difference if
// it is non-negative and record the quotient bit.
module idiv_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);

  logic [W:0] shifted;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    shifted = {rem_i, quo_i[W-1]};
    diff    = shifted - {1'b0, dvs_i};
    fits    = ~diff[W];
    if (fits) begin
      rem_o = diff[W-1:0];
    end else begin
      rem_o = shifted[W-1:0];
    end
    quo_o = {quo_i[W-2:0], fits};
  end

endmodule

// File: rtl/idiv_ctrl.sv
module idiv_ctrl
  import idiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        annul_i,
  input  logic        dvs_zero_i,
  output idiv_state_e state_o,
  output logic        load_en_o,
  output logic        step_en_o,
  output logic        fin_en_o,
  output logic        zero_en_o,
  output logic        stall_o
);

  localparam int LAT = W + 4;
  localparam int CW  = $clog2(LAT + 1);
  localparam logic [CW-1:0] FIN_AT   = CW'(LAT - 2);
  localparam logic [CW-1:0] STEP_END = CW'(W);

  idiv_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          cnt_clr;
  logic          cnt_inc;

  always_comb begin
    state_d   = state_q;
    load_en_o = 1'b0;
    step_en_o = 1'b0;
    fin_en_o  = 1'b0;
    zero_en_o = 1'b0;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (dvs_zero_i) begin
            state_d = ST_ZERO;
          end else begin
            state_d   = ST_ITER;
            load_en_o = 1'b1;
            cnt_clr   = 1'b1;
          end
        end
      end
      ST_ZERO: begin
        zero_en_o = 1'b1;
        state_d   = ST_DONE;
      end
      ST_ITER: begin
        if (annul_i) begin
          state_d = ST_IDLE;
        end else if (cnt_q == FIN_AT) begin
          fin_en_o = 1'b1;
          state_d  = ST_DONE;
        end else begin
          cnt_inc   = 1'b1;
          step_en_o = (cnt_q < STEP_END);
        end
      end
      ST_DONE: begin
        if (!start_i) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_clr) begin
      cnt_q <= '0;
    end else if (cnt_inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign state_o = state_q;
  assign stall_o = ((state_q == ST_IDLE) && start_i) ||
                   (state_q == ST_ITER) || (state_q == ST_ZERO);

endmodule

// File: rtl/idiv_core.sv
module idiv_core
  import idiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic         annul_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [2*W-1:0] result_o,
  output logic         ready_o,
  output logic         stall_o
);

  localparam int RW = 2 * W;

  logic        rst_int_n;
  idiv_state_e state;
  logic        load_en, step_en, fin_en, zero_en;
  logic        dvs_zero;

  logic [W-1:0] rem_q, quo_q, dvs_q;
  logic         negq_q, negr_q;
  logic [RW-1:0] res_q;

  logic [W-1:0] a_mag, b_mag;
  logic [W-1:0] rem_nx, quo_nx;
  logic [W-1:0] quo_fix, rem_fix;
  logic         a_neg, b_neg;

  idiv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign dvs_zero = (divisor_i == '0);
  assign a_neg    = signed_i & dividend_i[W-1];
  assign b_neg    = signed_i & divisor_i[W-1];

  idiv_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .annul_i    (annul_i),
    .dvs_zero_i (dvs_zero),
    .state_o    (state),
    .load_en_o  (load_en),
    .step_en_o  (step_en),
    .fin_en_o   (fin_en),
    .zero_en_o  (zero_en),
    .stall_o    (stall_o)
  );

  // Operand magnitudes on load; quotient and remainder sign restore.
  logic [W-1:0] neg_in  [4];
  logic         neg_sel [4];
  logic [W-1:0] neg_out [4];

  assign neg_in[0]  = dividend_i;
  assign neg_sel[0] = a_neg;
  assign neg_in[1]  = divisor_i;
  assign neg_sel[1] = b_neg;
  assign neg_in[2]  = quo_q;
  assign neg_sel[2] = negq_q;
  assign neg_in[3]  = rem_q;
  assign neg_sel[3] = negr_q;

  for (genvar gi = 0; gi < 4; gi++) begin : g_neg
    idiv_negate #(.W(W)) u_neg (
      .val_i (neg_in[gi]),
      .neg_i (neg_sel[gi]),
      .val_o (neg_out[gi])
    );
  end

  assign a_mag   = neg_out[0];
  assign b_mag   = neg_out[1];
  assign quo_fix = neg_out[2];
  assign rem_fix = neg_out[3];

  idiv_step #(.W(W)) u_step (
    .rem_i (rem_q),
    .quo_i (quo_q),
    .dvs_i (dvs_q),
    .rem_o (rem_nx),
    .quo_o (quo_nx)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
    end else if (load_en) begin
      rem_q  <= '0;
      quo_q  <= a_mag;
      dvs_q  <= b_mag;
      negq_q <= a_neg ^ b_neg;
      negr_q <= a_neg;
    end else if (step_en) begin
      rem_q <= rem_nx;
      quo_q <= quo_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q <= '0;
    end else if (zero_en) begin
      res_q <= '0;
    end else if (fin_en) begin
      res_q <= {rem_fix, quo_fix};
    end
  end

  assign ready_o  = (state == ST_DONE);
  assign result_o = ready_o ? res_q : '0;

endmodule

// File: rtl/idiv_core_chk.sv
module idiv_core_chk
  import idiv_pkg::*;
#(
  parameter int W = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          annul_i,
  input logic [W-1:0]  divisor_i,
  input logic [2*W-1:0] result_o,
  input logic          ready_o,
  input logic          stall_o,
  input idiv_state_e   state
);

  localparam int LAT = W + 4;
  localparam int CW  = $clog2(LAT + 2) + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= CMAX;
    end else if (state == ST_IDLE && start_i && divisor_i != '0) begin
      lat_cnt <= {{(CW-1){1'b0}}, 1'b1};
    end else if (lat_cnt != CMAX) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  a_r4_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready_o) && $past(state) == ST_ITER) |-> (lat_cnt == CW'(LAT)));

  a_r5_no_stall_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> !stall_o);

  a_r6_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ZERO) |=> (ready_o && result_o == '0));

  a_r7_hold_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && start_i) |=> (ready_o && $stable(result_o)));

  a_r7_result_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> (result_o == '0));

  a_r8_annul_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ITER && annul_i) |=> !ready_o);

endmodule

bind idiv_core idiv_core_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .start_i   (start_i),
  .annul_i   (annul_i),
  .divisor_i (divisor_i),
  .result_o  (result_o),
  .ready_o   (ready_o),
  .stall_o   (stall_o),
  .state     (state)
);

// File: tb/idiv_core_test.sv
`timescale 1ns/1ps
module idiv_core_test;

  logic        clk;
  logic        rst_n;
  logic        start_i, signed_i, annul_i;
  logic [31:0] dividend_i, divisor_i;
  logic [63:0] result_o;
  logic        ready_o, stall_o;

  int checks;
  int failures;

  idiv_core uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .annul_i(annul_i), .dividend_i(dividend_i), .divisor_i(divisor_i),
    .result_o(result_o), .ready_o(ready_o), .stall_o(stall_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [63:0] ref_div(input logic [31:0] a,
                                          input logic [31:0] b,
                                          input logic sgn);
    longint q, r;
    if (b == 32'd0) return 64'd0;
    if (sgn) begin
      q = longint'($signed(a)) / longint'($signed(b));
      r = longint'($signed(a)) % longint'($signed(b));
    end else begin
      q = longint'({32'd0, a}) / longint'({32'd0, b});
      r = longint'({32'd0, a}) % longint'({32'd0, b});
    end
    return {r[31:0], q[31:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at a negedge with start low and unit idle.
  task automatic run_div(input logic [31:0] a, input logic [31:0] b,
                         input logic sgn, input int hold, input string req);
    int n;
    int exp_lat;
    bit stall_ok;
    logic [63:0] exp;
    exp     = ref_div(a, b, sgn);
    exp_lat = (b == 32'd0) ? 2 : 36;
    start_i = 1'b1; signed_i = sgn; dividend_i = a; divisor_i = b;
    #1;
    check(stall_o == 1'b1, "R5", "stall on issue", {63'd0, stall_o}, 64'd1);
    n = 0;
    stall_ok = 1'b1;
    while (n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (ready_o) break;
      if (!stall_o) stall_ok = 1'b0;
    end
    check(stall_ok, "R5", "stall held while busy", 64'd0, 64'd1);
    check(n == exp_lat, (b == 0) ? "R6" : "R4", "latency",
          64'(n), 64'(exp_lat));
    check(result_o == exp, req, "result", result_o, exp);
    check(stall_o == 1'b0, "R5", "stall low when ready", {63'd0, stall_o}, 64'd0);
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); @(negedge clk);
      check(ready_o && result_o == exp, "R7", "hold while start high",
            result_o, exp);
    end
    start_i = 1'b0;
    @(posedge clk); @(negedge clk);
    check(!ready_o && result_o == 64'd0, "R7", "release after start low",
          {ready_o, result_o[62:0]}, 64'd0);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb;
    bit quiet;
    checks = 0; failures = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; signed_i = 1'b0; annul_i = 1'b0;
    dividend_i = '0; divisor_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!ready_o && !stall_o && result_o == 0, "R1", "reset state",
          {ready_o, stall_o, result_o[61:0]}, 64'd0);

    // R2 unsigned
    run_div(32'd7, 32'd2, 1'b0, 0, "R2");
    run_div(32'hFFFF_FFFF, 32'd1, 1'b0, 0, "R2");
    run_div(32'd5, 32'd9, 1'b0, 0, "R2");
    run_div(32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, 2, "R2");
    // R3 signed, all sign combinations and the overflow corner
    run_div(-32'sd7, 32'd2, 1'b1, 0, "R3");
    run_div(32'd7, -32'sd2, 1'b1, 0, "R3");
    run_div(-32'sd7, -32'sd2, 1'b1, 0, "R3");
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 0, "R3");
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 0, "R2");
    // R6 zero divisor, R7 hold
    run_div(32'd1234, 32'd0, 1'b1, 3, "R6");
    run_div(32'd0, 32'd0, 1'b0, 0, "R6");

    // R8 annul mid-iteration
    start_i = 1'b1; signed_i = 1'b0; dividend_i = 32'd100; divisor_i = 32'd3;
    repeat (10) @(posedge clk);
    @(negedge clk) begin annul_i = 1'b1; start_i = 1'b0; end
    @(posedge clk); @(negedge clk) annul_i = 1'b0;
    check(!ready_o && !stall_o, "R8", "idle after annul",
          {62'd0, ready_o, stall_o}, 64'd0);
    quiet = 1'b1;
    repeat (40) begin
      @(posedge clk); @(negedge clk);
      if (ready_o || stall_o) quiet = 1'b0;
    end
    check(quiet, "R8", "no ready after annul", 64'd0, 64'd1);
    run_div(32'd100, 32'd3, 1'b0, 0, "R8");

    // Random mix
    for (int k = 0; k < 40; k++) begin
      ra = $urandom; rb = $urandom;
      if (k % 4 == 0) rb = rb >> 20;
      if (k % 9 == 0) rb = 32'd0;
      run_div(ra, rb, k[0], k % 3, k[0] ? "R3" : "R2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule